// File: doc/BRIEF.md
# Periodic Interrupt Timer With Prescaler

This block is a 16-bit down-counter that raises a periodic interrupt. A small register bus gives access to three 16-bit registers: a configuration and status word, a modulus, and a count that can only be read. The counter steps on a clock enable. A prescaler makes that enable from the bus clock, with a division factor of 2 raised to (code + 1), so from 2 to 65536 bus clocks per step.

When the counter is at zero on a step, it either reloads from the modulus (reload mode) or wraps to 0xFFFF (free-running mode). At the same time it sets a sticky event flag. The interrupt output is a level: it is high while the flag and the interrupt enable are both set. Software clears the flag by writing a one to it, or by writing the modulus. Software chooses whether a new modulus value is loaded into the counter at once or waits for the next reload.

The register bus is a plain single-cycle write strobe with a combinational read. It has no handshake and no back-pressure: every write is taken on the clock edge where `bus_wr` is high.

Top module: `pit_timer`

## Requirements
- R1: After reset the configuration word reads 0, the modulus reads 0, the count reads 0xFFFF and `irq` is low.
- R2: Register select uses byte address bits [2:1]: 0 is configuration, 1 is modulus, 2 is count. An odd address or select 3 is ignored on write and reads 0. Configuration fields are: bit 0 run enable, bit 1 reload mode, bit 2 event flag, bit 3 interrupt enable, bit 4 immediate modulus load, bits 11:8 prescaler code. All other bits read 0.
- R3: A write to the count register has no effect on any register.
- R4: While enabled, the counter steps once every 2^(code+1) bus clocks. The first step after a restart comes 2^(code+1) clocks after the restarting write.
- R5: In reload mode, a step at zero loads the modulus, so one period is (modulus+1) steps.
- R6: In free-running mode, a step at zero loads 0xFFFF.
- R7: Every step at zero sets the event flag. Writing 1 to bit 2 of the configuration word clears the flag, and writing 0 leaves it unchanged. If a step at zero falls in the same cycle as a clear, the flag is set.
- R8: `irq` is high exactly when the event flag and the interrupt enable are both 1, and it changes the cycle after the write or step that causes the change.
- R9: Any modulus write clears the event flag.
- R10: With immediate load set, a modulus write also loads the counter with the written value and restarts the prescaler phase.
- R11: With immediate load clear, in reload mode, a modulus write leaves the running count alone; the new value is used at the next reload.
- R12: A configuration write that changes only the interrupt enable or the flag bit leaves the count and the prescaler phase alone. Any other change loads the counter with the new limit (the modulus in reload mode, otherwise 0xFFFF) and restarts the prescaler phase.
- R13: While run enable is 0, the count and the prescaler phase hold, and the event flag is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume at most one register write per cycle, a write data value that is stable across the edge, and an address that is either aligned or expected to be dropped. The bench drives every input 1 ns after a rising edge and holds it through the next edge. It writes one register at a time, so each step or reload can be tied to a single write. The timing sweeps use prescaler codes 0 to 5 and moduli 0 to 3. With these values both the first and the second interrupt period of every combination fall well within the run, so the step and reload rules are checked at each point, including where a flag clear is close to a step.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int PRE_W    = 4;
  localparam int BIT_EN   = 0;
  localparam int BIT_RLD  = 1;
  localparam int BIT_FLAG = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_OVW  = 4;
  localparam int PRE_LSB  = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             ovw;
    logic             ie;
    logic             flag;
    logic             rld;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/pit_prescaler.sv
`timescale 1ns/1ps
module pit_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clear,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int PC_W = 1 << PRE_W;

  logic [PC_W-1:0] phase_q;
  logic [PC_W-1:0] last;

  // last phase value = 2^(pre+1) - 1
  always_comb begin
    last = {PC_W{1'b1}} >> (PC_W - 1 - int'(pre));
    tick = en && (phase_q == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clear) begin
      phase_q <= '0;
    end else if (en) begin
      if (tick) phase_q <= '0;
      else      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/pit_counter.sv
`timescale 1ns/1ps
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rld,
  input  logic [CNT_W-1:0] modulus,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             terminal
);
  logic [CNT_W-1:0] count_q;

  assign terminal = tick && (count_q == '0) && !restart && !load;
  assign count    = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
    end else if (restart) begin
      count_q <= restart_val;
    end else if (load) begin
      count_q <= load_val;
    end else if (tick) begin
      if (count_q == '0) count_q <= rld ? modulus : '1;
      else               count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/pit_regs.sv
`timescale 1ns/1ps
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [CNT_W-1:0] wdata,
  input  logic             terminal,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] modulus,
  output logic             restart,
  output logic [CNT_W-1:0] restart_val,
  output logic             load
);
  ctrl_t            cfg_q;
  logic [CNT_W-1:0] mod_q;
  logic             wr_ctrl;
  logic             wr_mod;
  logic             cfg_change;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[CNT_W-1:PRE_LSB+PRE_W], wdata[PRE_LSB-1:BIT_OVW+1]};

  assign wr_ctrl = wr && (sel == SEL_CTRL);
  assign wr_mod  = wr && (sel == SEL_MOD);

  assign cfg_change = (wdata[BIT_EN]  != cfg_q.en)  ||
                      (wdata[BIT_RLD] != cfg_q.rld) ||
                      (wdata[BIT_OVW] != cfg_q.ovw) ||
                      (wdata[PRE_LSB +: PRE_W] != cfg_q.pre);

  assign restart     = wr_ctrl && cfg_change;
  assign restart_val = wdata[BIT_RLD] ? mod_q : '1;
  assign load        = wr_mod && cfg_q.ovw;

  assign ctrl    = cfg_q;
  assign modulus = mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      mod_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_q.en  <= wdata[BIT_EN];
        cfg_q.rld <= wdata[BIT_RLD];
        cfg_q.ie  <= wdata[BIT_IE];
        cfg_q.ovw <= wdata[BIT_OVW];
        cfg_q.pre <= wdata[PRE_LSB +: PRE_W];
      end
      if (wr_mod) mod_q <= wdata;
      if (terminal)
        cfg_q.flag <= 1'b1;
      else if ((wr_ctrl && wdata[BIT_FLAG]) || wr_mod)
        cfg_q.flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  reg_sel_e         sel;
  ctrl_t            cfg;
  logic [CNT_W-1:0] modulus;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] restart_val;
  logic             restart;
  logic             load;
  logic             tick;
  logic             terminal;
  logic             unused_hi_addr;

  assign unused_hi_addr = ^bus_addr[ADDR_W-1:2] ^ 1'b0;

  always_comb begin
    if (bus_addr[0]) sel = SEL_NONE;
    else             sel = reg_sel_e'(bus_addr[2:1]);
  end

  pit_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .terminal(terminal), .ctrl(cfg), .modulus(modulus), .restart(restart),
    .restart_val(restart_val), .load(load)
  );

  pit_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .clear(restart || load),
    .pre(cfg.pre), .tick(tick)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rld(cfg.rld), .modulus(modulus),
    .restart(restart), .restart_val(restart_val), .load(load),
    .load_val(bus_wdata), .count(count), .terminal(terminal)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        bus_rdata[BIT_EN]            = cfg.en;
        bus_rdata[BIT_RLD]           = cfg.rld;
        bus_rdata[BIT_FLAG]          = cfg.flag;
        bus_rdata[BIT_IE]            = cfg.ie;
        bus_rdata[BIT_OVW]           = cfg.ovw;
        bus_rdata[PRE_LSB +: PRE_W]  = cfg.pre;
      end
      SEL_MOD:  bus_rdata = modulus;
      SEL_CNT:  bus_rdata = count;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = cfg.ie & cfg.flag;
endmodule

// File: rtl/pit_timer_chk.sv
`timescale 1ns/1ps
module pit_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       sel,
  input logic             tick,
  input logic             terminal,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] modulus,
  input logic             en,
  input logic             rld,
  input logic             flag,
  input logic             restart,
  input logic             load,
  input logic             irq
);
  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0 && !restart && !load) |=> (count == $past(count) - 1'b1));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (terminal && rld) |=> (count == $past(modulus)));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (terminal && !rld) |=> (count == {CNT_W{1'b1}}));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terminal |=> flag);

  // R9
  mod_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == 2'd1 && !terminal) |=> !flag);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart && !load) |=> $stable(count));

  // R13
  idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !terminal);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(terminal) || $past(bus_wr && sel == 2'd0)));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .sel(sel), .tick(tick),
  .terminal(terminal), .count(count), .modulus(modulus), .en(cfg.en),
  .rld(cfg.rld), .flag(cfg.flag), .restart(restart), .load(load), .irq(irq)
);

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;
  localparam logic [15:0] EN = 16'h0001, RLD = 16'h0002, FLG = 16'h0004,
                          IE = 16'h0008, OVW = 16'h0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pit_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #0.5;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!irq && n < 5000);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    int per;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd2, v); check("R1 modulus", v, 0);
    rd(3'd4, v); check("R1 count", v, 16'hFFFF);
    check("R1 irq", irq, 0);

    // R2 field layout and unused bits
    wr(3'd0, 16'hF0E0); rd(3'd0, v); check("R2 unused bits", v, 0);
    wr(3'd0, 16'h0F1A); rd(3'd0, v); check("R2 fields", v, 16'h0F1A);
    wr(3'd3, 16'h0001); rd(3'd0, v); check("R2 odd address ignored", v, 16'h0F1A);
    rd(3'd6, v); check("R2 select 3 reads zero", v, 0);
    wr(3'd0, 16'h0000);

    // R10, R13: immediate load while stopped, then hold
    wr(3'd0, OVW);
    wr(3'd2, 16'd3);
    rd(3'd4, v); check("R10 immediate load", v, 3);
    edges(40);
    rd(3'd4, v); check("R13 count holds", v, 3);
    rd(3'd0, v); check("R13 no flag while stopped", v & FLG, 0);
    // R3 count write ignored
    wr(3'd4, 16'h1234);
    rd(3'd4, v); check("R3 count unchanged", v, 3);
    rd(3'd2, v); check("R3 modulus unchanged", v, 3);

    // R4 R5 R7: sweep prescaler code and modulus
    for (int p = 0; p < 6; p++) begin
      for (int m = 0; m < 4; m++) begin
        per = (m + 1) << (p + 1);
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'(m));
        wr(3'd0, EN | RLD | IE | 16'(p << 8));
        wait_irq(n);
        check($sformatf("R4 R5 first period p=%0d m=%0d", p, m), n, per);
        rd(3'd4, v); check("R5 reload value", v, m);
        wr(3'd0, EN | RLD | IE | FLG | 16'(p << 8));
        check("R7 write one clears flag", irq, 0);
        wait_irq(n);
        check($sformatf("R4 R5 second period p=%0d m=%0d", p, m), n, per - 1);
      end
    end

    // R12 interrupt-enable-only write leaves counting alone
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd5);
    wr(3'd0, EN | RLD);
    edges(3);
    wr(3'd0, EN | RLD | IE);
    wait_irq(n);
    check("R12 period unaffected by enable write", n, 8);

    // R11 deferred modulus
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd3);
    wr(3'd0, EN | RLD | IE);
    edges(2);
    wr(3'd2, 16'd7);
    wait_irq(n);
    check("R11 old modulus runs out", n, 5);
    rd(3'd4, v); check("R11 new modulus at reload", v, 7);

    // R6 free run wrap, R10 load restarts prescaler
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd0);
    wr(3'd0, EN | IE | OVW);
    rd(3'd4, v); check("R12 restart loads 0xFFFF", v, 16'hFFFF);
    wr(3'd2, 16'd2);
    wait_irq(n);
    check("R10 period after load", n, 6);
    rd(3'd4, v); check("R6 wrap value", v, 16'hFFFF);
    edges(2);
    rd(3'd4, v); check("R6 continues down", v, 16'hFFFE);

    // R7 R8 R9 flag and interrupt gating
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd1);
    wr(3'd0, EN | RLD);
    edges(6);
    wr(3'd0, 16'h0000);
    rd(3'd0, v); check("R7 flag set by event", v, FLG);
    check("R8 irq low without enable", irq, 0);
    wr(3'd0, IE);
    check("R8 irq high with enable", irq, 1);
    wr(3'd0, IE);
    rd(3'd0, v); check("R7 write zero keeps flag", v, IE | FLG);
    wr(3'd2, 16'd5);
    rd(3'd0, v); check("R9 modulus write clears flag", v, IE);
    check("R8 irq drops", irq, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule